// File: doc/BRIEF.md
# Device Load Ordering Queue

This block holds up to eight pending 32-bit loads aimed at device memory and decides, every cycle, which of them goes out on the bus next. Loads are accepted in program order through a valid/ready enqueue port, each carrying an address, a region number and a two-bit device attribute. A younger load may overtake an older one only when the ordering rules for that pair allow it. Loads that leave through the valid/ready issue port stay in the queue until a completion strobe retires them by tag.

The attribute encoding runs from strongest to weakest: 0 (no gathering, no reordering, no early acknowledge), 1 (same but with early acknowledge), 2 (reordering allowed, no gathering), 3 (gathering, reordering and early acknowledge all allowed). Two static inputs tune the rules. One input makes distinct regions that share the same strong attribute behave as a single ordered stream. The other treats every load as the strongest kind, which always gives correct results at the cost of concurrency.

Top module: `dev_order_queue`

## Requirements
- R1: After reset the queue is empty: `iss_valid` is 0 and `enq_ready` is 1.
- R2: The queue holds 8 entries; with 8 occupied `enq_ready` is 0 and an enqueue attempt is dropped; `enq_ready` returns to 1 once a completion frees an entry.
- R3: For two loads to the same region where at least one carries attribute 0 or 1, the younger is not issued until the older has been retired on the completion port.
- R4: For two loads to the same region that both carry attribute 2 or 3, the younger may issue while the older is still incomplete, and may overtake older loads that are blocked.
- R5: Loads to different regions with different attributes are not ordered against each other.
- R6: For loads to different regions with the same attribute 0 or 1, the younger may issue freely when `same_attr_order` is 0 and waits for the older to retire when it is 1; regions sharing attribute 2 or 3 are unordered in both settings.
- R7: With `force_strict` at 1 every pair is ordered: at most one load is issued and incomplete at a time, and loads issue in enqueue order.
- R8: Among the loads that may issue, the oldest is offered; `iss_tag` names its entry and the same value on `cmp_tag` with `cmp_valid` retires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_strict | input | 1 | Treat every load as attribute 0 |
| same_attr_order | input | 1 | Order distinct regions sharing a strong attribute |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Queue has a free entry |
| enq_addr | input | 32 | Load address |
| enq_region | input | 4 | Region number |
| enq_attr | input | 2 | Device attribute, 0 strongest to 3 weakest |
| iss_valid | output | 1 | A load is eligible to issue |
| iss_ready | input | 1 | Bus accepts the offered load |
| iss_addr | output | 32 | Address of the offered load |
| iss_tag | output | 3 | Entry tag of the offered load |
| cmp_valid | input | 1 | Completion strobe |
| cmp_tag | input | 3 | Tag of the load being retired |

## Verification
The bench uses the default parameters: eight entries, 32-bit addresses and 4-bit region numbers. Eight entries are few enough that filling the queue, trying one extra enqueue and draining it in strict mode fits in a short run, and a 4-bit region field gives enough distinct regions to pair same-region, cross-region same-attribute and cross-region mixed-attribute loads in one sequence. Each scenario holds completions back so that blocked loads, overtaking loads and the moment a retirement unblocks a waiter are all visible at the issue port.

// File: rtl/dq_pkg.sv
// Shared types and the pairwise ordering rule for the device load queue.
// Assumes attribute bit 1 set means the attribute permits reordering.
package dq_pkg;

    typedef logic [1:0] dev_attr_t;

    // Returns 1 when a younger load must wait for an older one to retire.
    function automatic logic pair_ordered(
        input logic      strict,
        input logic      merge_same_attr,
        input logic      same_region,
        input dev_attr_t older_attr,
        input dev_attr_t younger_attr
    );
        logic either_strong;
        logic shared_strong;
        either_strong = !older_attr[1] || !younger_attr[1];
        shared_strong = (older_attr == younger_attr) && !older_attr[1];
        return strict
            || (same_region && either_strong)
            || (!same_region && merge_same_attr && shared_strong);
    endfunction

endpackage

// File: rtl/dq_slots.sv
// Entry storage for the device load queue: payload, occupancy, issued
// flags and an age matrix (older_q[i][j] = 1 when entry j is older than i).
// Assumes completions only name entries that are valid and issued.
module dq_slots #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int RW    = 4,
    localparam int TAGW = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    force_strict,
    input  logic                    enq_fire,
    input  logic [AW-1:0]           enq_addr,
    input  logic [RW-1:0]           enq_region,
    input  dq_pkg::dev_attr_t       enq_attr,
    input  logic                    iss_fire,
    input  logic [TAGW-1:0]         iss_idx,
    input  logic                    cmp_valid,
    input  logic [TAGW-1:0]         cmp_tag,
    output logic [DEPTH-1:0]        valid_q,
    output logic [DEPTH-1:0]        issued_q,
    output logic [AW-1:0]           addr_q   [DEPTH],
    output logic [RW-1:0]           region_q [DEPTH],
    output dq_pkg::dev_attr_t       attr_q   [DEPTH],
    output logic [DEPTH-1:0]        older_q  [DEPTH],
    output logic [TAGW-1:0]         free_idx,
    output logic                    full
);

    logic [DEPTH-1:0] retire_hit;

    // Decode the completion tag into a per-entry strobe.
    always_comb begin
        retire_hit = '0;
        if (cmp_valid) retire_hit[cmp_tag] = 1'b1;
    end

    // Find the lowest-numbered free entry.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!valid_q[i]) free_idx = TAGW'(i);
    end

    assign full = &valid_q;

    // Update occupancy, issue state, payload and ages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= '0;
            issued_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                older_q[i]  <= '0;
                addr_q[i]   <= '0;
                region_q[i] <= '0;
                attr_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retire_hit[i]) begin
                    valid_q[i]  <= 1'b0;
                    issued_q[i] <= 1'b0;
                end
            end
            if (iss_fire) issued_q[iss_idx] <= 1'b1;
            if (enq_fire) begin
                valid_q[free_idx]  <= 1'b1;
                issued_q[free_idx] <= 1'b0;
                addr_q[free_idx]   <= enq_addr;
                region_q[free_idx] <= enq_region;
                attr_q[free_idx]   <= enq_attr;
                for (int i = 0; i < DEPTH; i++) older_q[i][free_idx] <= 1'b0;
                older_q[free_idx] <= valid_q & ~retire_hit;
            end
        end
    end

    // Assertion helpers: hazards seen from the entry being issued.
    logic strong_hazard;
    logic [TAGW-1:0] free_idx_d;
    always_comb begin
        strong_hazard = 1'b0;
        for (int j = 0; j < DEPTH; j++)
            if (valid_q[j] && older_q[iss_idx][j]
                && region_q[j] == region_q[iss_idx]
                && (!attr_q[j][1] || !attr_q[iss_idx][1]))
                strong_hazard = 1'b1;
    end
    always_ff @(posedge clk) free_idx_d <= free_idx;

    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));
    a_r2_enq_lands: assert property (@(posedge clk) disable iff (!rst_n)
        enq_fire |=> valid_q[free_idx_d] && !issued_q[free_idx_d]);
    a_r3_no_strong_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> !strong_hazard);
    a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && force_strict) |-> (issued_q == '0));
    a_r8_retire_issued: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> (valid_q[cmp_tag] && issued_q[cmp_tag]));
    a_r8_issue_unissued: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |-> (valid_q[iss_idx] && !issued_q[iss_idx]));

endmodule

// File: rtl/dq_pick.sv
// Issue selection: an entry is eligible when it is valid, not yet issued
// and no older valid entry orders it; the oldest eligible entry wins.
// Assumes the age matrix is a strict total order over valid entries.
module dq_pick #(
    parameter int DEPTH = 8,
    parameter int RW    = 4,
    localparam int TAGW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                force_strict,
    input  logic                same_attr_order,
    input  logic [DEPTH-1:0]    valid_q,
    input  logic [DEPTH-1:0]    issued_q,
    input  logic [RW-1:0]       region_q [DEPTH],
    input  dq_pkg::dev_attr_t   attr_q   [DEPTH],
    input  logic [DEPTH-1:0]    older_q  [DEPTH],
    output logic                pick_valid,
    output logic [TAGW-1:0]     pick_idx
);

    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] pick;

    for (genvar i = 0; i < DEPTH; i++) begin : g_elig
        logic blk;
        // Scan older entries for any that order this one.
        always_comb begin
            blk = 1'b0;
            for (int j = 0; j < DEPTH; j++)
                if (valid_q[j] && older_q[i][j]
                    && dq_pkg::pair_ordered(force_strict, same_attr_order,
                                            region_q[j] == region_q[i],
                                            attr_q[j], attr_q[i]))
                    blk = 1'b1;
        end
        assign elig[i] = valid_q[i] & ~issued_q[i] & ~blk;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_oldest
        assign pick[i] = elig[i] & ~|(elig & older_q[i]);
    end

    // Encode the winning entry.
    always_comb begin
        pick_idx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (pick[i]) pick_idx = TAGW'(i);
    end

    assign pick_valid = |elig;

    a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick) && (pick_valid == (pick != '0)));

endmodule

// File: rtl/dev_order_queue.sv
// Top of the device load ordering queue: accepts loads in program order,
// offers the oldest load the ordering rules release, and retires loads
// by tag. Assumes the bus completes only loads it accepted.
module dev_order_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int RW    = 4,
    localparam int TAGW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            force_strict,
    input  logic            same_attr_order,
    input  logic            enq_valid,
    output logic            enq_ready,
    input  logic [AW-1:0]   enq_addr,
    input  logic [RW-1:0]   enq_region,
    input  logic [1:0]      enq_attr,
    output logic            iss_valid,
    input  logic            iss_ready,
    output logic [AW-1:0]   iss_addr,
    output logic [TAGW-1:0] iss_tag,
    input  logic            cmp_valid,
    input  logic [TAGW-1:0] cmp_tag
);

    logic [DEPTH-1:0]   valid_q;
    logic [DEPTH-1:0]   issued_q;
    logic [AW-1:0]      addr_q   [DEPTH];
    logic [RW-1:0]      region_q [DEPTH];
    dq_pkg::dev_attr_t  attr_q   [DEPTH];
    logic [DEPTH-1:0]   older_q  [DEPTH];
    logic [TAGW-1:0]    free_idx;
    logic               full;
    logic               enq_fire;
    logic               iss_fire;

    assign enq_ready = ~full;
    assign enq_fire  = enq_valid & enq_ready;
    assign iss_fire  = iss_valid & iss_ready;
    assign iss_addr  = addr_q[iss_tag];

    dq_slots #(.DEPTH(DEPTH), .AW(AW), .RW(RW)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .force_strict (force_strict),
        .enq_fire     (enq_fire),
        .enq_addr     (enq_addr),
        .enq_region   (enq_region),
        .enq_attr     (enq_attr),
        .iss_fire     (iss_fire),
        .iss_idx      (iss_tag),
        .cmp_valid    (cmp_valid),
        .cmp_tag      (cmp_tag),
        .valid_q      (valid_q),
        .issued_q     (issued_q),
        .addr_q       (addr_q),
        .region_q     (region_q),
        .attr_q       (attr_q),
        .older_q      (older_q),
        .free_idx     (free_idx),
        .full         (full)
    );

    dq_pick #(.DEPTH(DEPTH), .RW(RW)) u_pick (
        .clk             (clk),
        .rst_n           (rst_n),
        .force_strict    (force_strict),
        .same_attr_order (same_attr_order),
        .valid_q         (valid_q),
        .issued_q        (issued_q),
        .region_q        (region_q),
        .attr_q          (attr_q),
        .older_q         (older_q),
        .pick_valid      (iss_valid),
        .pick_idx        (iss_tag)
    );

    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q == '1) |-> !enq_ready);

endmodule

// File: tb/dev_order_queue_test.sv
`timescale 1ns/1ps
// Scoreboard bench: scenario tasks push expected issue addresses, a
// monitor pops and compares them as loads leave the issue port.
module dev_order_queue_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        force_strict = 1'b0;
    logic        same_attr_order = 1'b0;
    logic        enq_valid = 1'b0;
    logic        enq_ready;
    logic [31:0] enq_addr = '0;
    logic [3:0]  enq_region = '0;
    logic [1:0]  enq_attr = '0;
    logic        iss_valid;
    logic        iss_ready = 1'b0;
    logic [31:0] iss_addr;
    logic [2:0]  iss_tag;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_tag = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_addr [$];
    string       exp_req  [$];
    logic [2:0]  tag_of   [logic [31:0]];

    always #2.5 clk = ~clk;

    dev_order_queue uut (
        .clk(clk), .rst_n(rst_n), .force_strict(force_strict),
        .same_attr_order(same_attr_order), .enq_valid(enq_valid),
        .enq_ready(enq_ready), .enq_addr(enq_addr), .enq_region(enq_region),
        .enq_attr(enq_attr), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_addr(iss_addr), .iss_tag(iss_tag), .cmp_valid(cmp_valid),
        .cmp_tag(cmp_tag)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic expect_issue(input logic [31:0] a, input string req);
        exp_addr.push_back(a);
        exp_req.push_back(req);
    endtask

    task automatic enq(input logic [31:0] a, input logic [3:0] r, input logic [1:0] at);
        tick();
        enq_valid = 1'b1; enq_addr = a; enq_region = r; enq_attr = at;
        tick();
        enq_valid = 1'b0;
    endtask

    task automatic complete(input logic [31:0] a);
        tick();
        cmp_valid = 1'b1;
        cmp_tag = tag_of.exists(a) ? tag_of[a] : 3'd0;
        tick();
        cmp_valid = 1'b0;
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_drained(input string req);
        checks++;
        if (exp_addr.size() != 0) begin
            fails++;
            $display("FAIL %s: actual=%0d pending issues expected=0 (next %h)",
                     req, exp_addr.size(), exp_addr[0]);
        end
        exp_addr.delete();
        exp_req.delete();
    endtask

    // Monitor: compare every accepted issue with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && iss_valid && iss_ready) begin
            checks++;
            tag_of[iss_addr] = iss_tag;
            if (exp_addr.size() == 0) begin
                fails++;
                $display("FAIL unexpected issue: actual=%h expected=none", iss_addr);
            end else begin
                logic [31:0] e;
                string rq;
                e  = exp_addr.pop_front();
                rq = exp_req.pop_front();
                if (e !== iss_addr) begin
                    fails++;
                    $display("FAIL %s: actual=%h expected=%h", rq, iss_addr, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        run(1);
        // R1: reset state
        check_bit("R1 iss_valid after reset", iss_valid, 1'b0);
        check_bit("R1 enq_ready after reset", enq_ready, 1'b1);

        // R3/R5: strong same-region pairs wait; mixed-attribute regions bypass
        iss_ready = 1'b1;
        expect_issue(32'h100, "R3 first strong load");
        expect_issue(32'h108, "R5 other region bypasses blocked load");
        enq(32'h100, 4'd1, 2'd0);
        enq(32'h104, 4'd1, 2'd0);
        enq(32'h108, 4'd3, 2'd1);
        enq(32'h10C, 4'd3, 2'd1);
        run(4);
        check_drained("R3/R5 first wave");
        check_bit("R3 younger strong loads held", iss_valid, 1'b0);
        expect_issue(32'h104, "R3 release after completion");
        complete(32'h100);
        run(3);
        check_drained("R3 attr0 release");
        expect_issue(32'h10C, "R3 attr1 release after completion");
        complete(32'h108);
        run(3);
        check_drained("R3 attr1 release");
        complete(32'h104);
        complete(32'h10C);

        // R8/R4: oldest eligible first; reorderable loads overtake
        iss_ready = 1'b0;
        enq(32'h200, 4'd2, 2'd3);
        enq(32'h204, 4'd2, 2'd3);
        enq(32'h208, 4'd2, 2'd2);
        expect_issue(32'h200, "R8 oldest first");
        expect_issue(32'h204, "R4 same region attr3 while older incomplete");
        expect_issue(32'h208, "R4 attr2 after attr3 same region");
        tick();
        iss_ready = 1'b1;
        run(4);
        check_drained("R8/R4 burst");
        expect_issue(32'h300, "R3 strong load");
        enq(32'h300, 4'd1, 2'd0);
        enq(32'h304, 4'd1, 2'd0);
        expect_issue(32'h20C, "R4 overtakes blocked load");
        enq(32'h20C, 4'd2, 2'd3);
        run(3);
        check_drained("R4 overtake");
        check_bit("R3 strong load still held", iss_valid, 1'b0);
        expect_issue(32'h304, "R3 release");
        complete(32'h300);
        run(3);
        check_drained("R3 release second");
        complete(32'h200); complete(32'h204); complete(32'h208);
        complete(32'h304); complete(32'h20C);

        // R6: distinct regions sharing a strong attribute
        same_attr_order = 1'b0;
        expect_issue(32'h400, "R6 mode0 first");
        expect_issue(32'h500, "R6 mode0 unordered");
        enq(32'h400, 4'd4, 2'd0);
        enq(32'h500, 4'd5, 2'd0);
        run(3);
        check_drained("R6 mode0");
        complete(32'h400); complete(32'h500);
        same_attr_order = 1'b1;
        expect_issue(32'h404, "R6 mode1 first");
        enq(32'h404, 4'd4, 2'd0);
        enq(32'h504, 4'd5, 2'd0);
        run(3);
        check_drained("R6 mode1 hold");
        check_bit("R6 mode1 younger waits", iss_valid, 1'b0);
        expect_issue(32'h504, "R6 mode1 release");
        complete(32'h404);
        run(3);
        check_drained("R6 mode1 release");
        complete(32'h504);
        expect_issue(32'h600, "R6 mode1 attr3 first");
        expect_issue(32'h700, "R6 mode1 attr3 unordered");
        enq(32'h600, 4'd6, 2'd3);
        enq(32'h700, 4'd7, 2'd3);
        run(3);
        check_drained("R6 mode1 weak");
        complete(32'h600); complete(32'h700);
        same_attr_order = 1'b0;

        // R7: force strict ordering on weak loads
        force_strict = 1'b1;
        expect_issue(32'h800, "R7 first");
        enq(32'h800, 4'd8, 2'd3);
        enq(32'h804, 4'd9, 2'd3);
        enq(32'h808, 4'd8, 2'd2);
        run(3);
        check_drained("R7 one outstanding");
        check_bit("R7 others held", iss_valid, 1'b0);
        expect_issue(32'h804, "R7 program order second");
        complete(32'h800);
        run(3);
        check_drained("R7 second");
        expect_issue(32'h808, "R7 program order third");
        complete(32'h804);
        run(3);
        check_drained("R7 third");
        complete(32'h808);

        // R2: fill, try an extra load, drain
        iss_ready = 1'b0;
        for (int k = 0; k < 8; k++)
            enq(32'hA00 + 32'(4 * k), 4'(k), 2'd3);
        run(1);
        check_bit("R2 enq_ready low when full", enq_ready, 1'b0);
        enq(32'h9FC, 4'd0, 2'd3);
        check_bit("R2 still full after dropped enqueue", enq_ready, 1'b0);
        for (int k = 0; k < 8; k++)
            expect_issue(32'hA00 + 32'(4 * k), "R2/R7 drain order");
        tick();
        iss_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            run(3);
            complete(32'hA00 + 32'(4 * k));
            if (k == 0) check_bit("R2 ready after completion", enq_ready, 1'b1);
        end
        run(3);
        check_drained("R2 drain");
        check_bit("R2 dropped load never stored", iss_valid, 1'b0);
        check_bit("R2 empty again", enq_ready, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule